// File: doc/BRIEF.md
# Configurable Eight-Pin GPIO Port

This block is one general-purpose I/O port with eight pins. Software reaches it over a simple register bus with an address, a write enable, write data and read data. The port holds an output data register, which can also be written through set-only and clear-only aliases. It also holds a read-only view of the pin levels, a wake mask, and two mode registers that give each pin a 4-bit mode code.

For each pin, the mode code turns the output data bit and the peripheral's value into pad controls: output enable, driven value, pull enable, pull direction, open-drain, analog select and peripheral select. The pad wrapper supplies pin levels that are already synchronized. The block compares them with the levels of the previous cycle and raises `wake_pending` while a pin that is in the wake mask has changed.

The design has no sequencer, so it has no enumerated states or transitions. All storage is four register groups: output data, wake mask, per-pin modes and the previous pin levels. Every pad control is a combinational function of those registers and the live inputs.

Top module: `gpio_port8`

## Requirements
- R1: After reset the output data is 0x00, the wake mask is 0x00, and every mode field is 0x4. All pad controls read 0 and `wake_pending` is 0.
- R2: A write to address 0 loads the output data from `bus_wdata[7:0]`. Reading address 0 returns it in bits 7..0, with the upper bits 0.
- R3: A write to address 1 ORs the ones of `bus_wdata[7:0]` into the output data. Reading address 1 returns the output data.
- R4: A write to address 2 clears each output data bit written as one and keeps the others. Reading address 2 returns the output data.
- R5: Address 5 holds the modes of pins 0..3 and address 6 holds the modes of pins 4..7. Pin i uses bits [4*(i mod 4)+3 : 4*(i mod 4)] of its register. Both registers read back what was written.
- R6: Mode 0x0 (analog) sets `pad_ana`, turns the driver and the pull off, and makes that pin's bit at input address 3 read 1 whatever the pin level.
- R7: Mode 0x4 (floating input) and every code not named in R6 or R8–R11 turn all pad controls off. The pin's bit at address 3 follows `pin_in`.
- R8: Mode 0x8 (pulled input) sets `pad_pull_en` with the driver off. `pad_pull_up` equals the pin's output data bit: 1 selects pull-up and 0 selects pull-down.
- R9: Mode 0x1 (push-pull) sets `pad_oe` and drives `pad_out` with the output data bit.
- R10: Mode 0x5 (open-drain) sets `pad_od`. It drives low (`pad_oe`=1, `pad_out`=0) when the data bit is 0 and releases the pin (`pad_oe`=0) when the bit is 1. It never drives high.
- R11: Mode 0x9 (peripheral output) sets `pad_oe` and `pad_alt` and drives `pad_out` from `alt_out`, ignoring the output data bit.
- R12: Address 4 holds the wake mask. `wake_pending` is 1 in a cycle exactly when some masked pin's `pin_in` differs from its value at the previous clock edge.
- R13: Writes to input address 3 change no register. A pad control reads 0 on any pin whose mode does not use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Synchronized pin levels |
| alt_out | input | 8 | Peripheral output values per pin |
| pad_oe | output | 8 | Output driver enable |
| pad_out | output | 8 | Driven value |
| pad_pull_en | output | 8 | Internal pull enable |
| pad_pull_up | output | 8 | Pull direction, 1 = up |
| pad_od | output | 8 | Open-drain mode flag |
| pad_ana | output | 8 | Analog select |
| pad_alt | output | 8 | Peripheral select |
| wake_pending | output | 1 | A masked pin changed level |

## Verification
A corrupted output data or mode register shows up on the pad outputs and on the read data in the same cycle, one clock edge after the write that caused it. The reason is that all pad controls and read data are decoded combinationally from those registers. A wrong previous-level register shows up as a missing or spurious `wake_pending` pulse in the cycle a masked pin toggles, and as a pulse that fails to clear at the next edge. The bench sets up one mixed pattern with a different mode on every pin, so that a decode slip between pins or between codes shows up as a wrong bit in a known position.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DOUT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DSET   = 3'd1;
    localparam logic [ADDR_W-1:0] A_DCLR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIN    = 3'd3;
    localparam logic [ADDR_W-1:0] A_WMASK  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE_L = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE_H = 3'd6;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_ANALOG = 4'h0,
        MODE_PP     = 4'h1,
        MODE_FLOAT  = 4'h4,
        MODE_OD     = 4'h5,
        MODE_PULL   = 4'h8,
        MODE_ALT    = 4'h9
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic pull_en;
        logic pull_up;
        logic od;
        logic ana;
        logic alt;
    } pad_ctl_t;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NPINS-1:0]        in_data,
    output logic [DATA_W-1:0]       rdata,
    output logic [NPINS-1:0]        dout_q,
    output logic [NPINS-1:0]        wmask_q,
    output logic [NPINS*MODE_W-1:0] mode_q
);

    localparam int HALF_W = NPINS * MODE_W / 2;
    localparam int MODE_TOT = NPINS * MODE_W;

    logic [NPINS-1:0] wbits;
    assign wbits = wdata[NPINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            wmask_q <= '0;
            mode_q  <= {NPINS{MODE_FLOAT}};
        end else if (we) begin
            unique case (addr)
                A_DOUT:   dout_q  <= wbits;
                A_DSET:   dout_q  <= dout_q | wbits;
                A_DCLR:   dout_q  <= dout_q & ~wbits;
                A_WMASK:  wmask_q <= wbits;
                A_MODE_L: mode_q[HALF_W-1:0] <= wdata[HALF_W-1:0];
                A_MODE_H: mode_q[MODE_TOT-1:HALF_W] <= wdata[HALF_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DOUT, A_DSET, A_DCLR: rdata[NPINS-1:0] = dout_q;
            A_DIN:    rdata[NPINS-1:0]  = in_data;
            A_WMASK:  rdata[NPINS-1:0]  = wmask_q;
            A_MODE_L: rdata[HALF_W-1:0] = mode_q[HALF_W-1:0];
            A_MODE_H: rdata[HALF_W-1:0] = mode_q[MODE_TOT-1:HALF_W];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_port_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              dout_bit,
    input  logic              alt_bit,
    output pad_ctl_t          ctl
);

    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_ANALOG: ctl.ana = 1'b1;
            MODE_PULL: begin
                ctl.pull_en = 1'b1;
                ctl.pull_up = dout_bit;
            end
            MODE_PP: begin
                ctl.oe  = 1'b1;
                ctl.val = dout_bit;
            end
            MODE_OD: begin
                ctl.od = 1'b1;
                ctl.oe = ~dout_bit;
            end
            MODE_ALT: begin
                ctl.oe  = 1'b1;
                ctl.alt = 1'b1;
                ctl.val = alt_bit;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] wmask,
    output logic             pending
);

    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    assign pending = |(wmask & (pin_in ^ prev_q));

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  alt_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pull_en,
    output logic [NPINS-1:0]  pad_pull_up,
    output logic [NPINS-1:0]  pad_od,
    output logic [NPINS-1:0]  pad_ana,
    output logic [NPINS-1:0]  pad_alt,
    output logic              wake_pending
);

    logic [NPINS-1:0]        dout_q;
    logic [NPINS-1:0]        wmask_q;
    logic [NPINS*MODE_W-1:0] mode_q;
    logic [NPINS-1:0]        in_data;

    assign in_data = pin_in | pad_ana;

    gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .in_data (in_data),
        .rdata   (bus_rdata),
        .dout_q  (dout_q),
        .wmask_q (wmask_q),
        .mode_q  (mode_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pad_ctl_t ctl;
        gpio_pin_ctl u_ctl (
            .mode     (mode_q[p*MODE_W +: MODE_W]),
            .dout_bit (dout_q[p]),
            .alt_bit  (alt_out[p]),
            .ctl      (ctl)
        );
        assign pad_oe[p]      = ctl.oe;
        assign pad_out[p]     = ctl.val;
        assign pad_pull_en[p] = ctl.pull_en;
        assign pad_pull_up[p] = ctl.pull_up;
        assign pad_od[p]      = ctl.od;
        assign pad_ana[p]     = ctl.ana;
        assign pad_alt[p]     = ctl.alt;
    end

    gpio_wake #(.NPINS(NPINS)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .wmask   (wmask_q),
        .pending (wake_pending)
    );

endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  dout_q,
    input logic [NPINS-1:0]  wmask_q,
    input logic [NPINS-1:0]  in_data,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_pull_en,
    input logic [NPINS-1:0]  pad_od,
    input logic [NPINS-1:0]  pad_ana,
    input logic [NPINS-1:0]  pad_alt,
    input logic              wake_pending
);

    a_r3_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DSET) |=>
            dout_q == ($past(dout_q) | $past(bus_wdata[NPINS-1:0])));

    a_r4_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DCLR) |=>
            dout_q == ($past(dout_q) & ~$past(bus_wdata[NPINS-1:0])));

    a_r13_din_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIN) |=> ($stable(dout_q) && $stable(wmask_q)));

    a_r12_wake_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pending |-> (wmask_q != '0));

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        a_r6_analog_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
            pad_ana[p] |-> (in_data[p] && !pad_oe[p] && !pad_pull_en[p]));

        a_r10_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
            pad_od[p] |-> !(pad_oe[p] && pad_out[p]));

        a_r8_pull_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pull_en[p] |-> !pad_oe[p]);

        a_r11_alt_drives: assert property (@(posedge clk) disable iff (!rst_n)
            pad_alt[p] |-> pad_oe[p]);

        a_r13_one_role: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({pad_ana[p], pad_pull_en[p], pad_od[p], pad_alt[p]}));
    end

endmodule

bind gpio_port8 gpio_port8_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .dout_q       (dout_q),
    .wmask_q      (wmask_q),
    .in_data      (in_data),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_pull_en  (pad_pull_en),
    .pad_od       (pad_od),
    .pad_ana      (pad_ana),
    .pad_alt      (pad_alt),
    .wake_pending (wake_pending)
);

// File: tb/test_gpio_port8.sv
`timescale 1ns/1ps
module test_gpio_port8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in;
    logic [7:0]  alt_out;
    logic [7:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_od, pad_ana, pad_alt;
    logic        wake_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_port8 i_gpio_port8 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_out(alt_out), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_od(pad_od),
        .pad_ana(pad_ana), .pad_alt(pad_alt), .wake_pending(wake_pending)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R1 dout", v, 16'h0000);
        rd(3'd4, v); check("R1 wmask", v, 16'h0000);
        rd(3'd5, v); check("R1 mode lo", v, 16'h4444);
        rd(3'd6, v); check("R1 mode hi", v, 16'h4444);
        check("R1 pads", {pad_oe, pad_pull_en | pad_od | pad_ana | pad_alt | pad_out}, 16'h0000);
        check("R1 wake", {15'd0, wake_pending}, 16'h0000);
    endtask

    task automatic t_data();
        logic [15:0] v;
        wr(3'd0, 16'hFF5A);
        rd(3'd0, v); check("R2 load", v, 16'h005A);
        wr(3'd1, 16'h0081);
        rd(3'd1, v); check("R3 set", v, 16'h00DB);
        wr(3'd2, 16'h0018);
        rd(3'd2, v); check("R4 clear", v, 16'h00C3);
        wr(3'd2, 16'h0000);
        rd(3'd0, v); check("R4 zero clear", v, 16'h00C3);
        wr(3'd3, 16'h00FF);
        rd(3'd0, v); check("R13 din write dout", v, 16'h00C3);
        rd(3'd4, v); check("R13 din write wmask", v, 16'h0000);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        wr(3'd5, 16'h5810);
        wr(3'd6, 16'h2F49);
        rd(3'd5, v); check("R5 mode lo", v, 16'h5810);
        rd(3'd6, v); check("R5 mode hi", v, 16'h2F49);
        wr(3'd0, 16'h0006);
        alt_out = 8'h10; pin_in = 8'h00;
        #1;
        check("R6 ana", {8'h0, pad_ana}, 16'h0001);
        check("R9 R10 R11 oe", {8'h0, pad_oe}, 16'h001A);
        check("R9 R11 out", {8'h0, pad_out}, 16'h0012);
        check("R8 pull_en", {8'h0, pad_pull_en}, 16'h0004);
        check("R8 pull_up", {8'h0, pad_pull_up}, 16'h0004);
        check("R10 od", {8'h0, pad_od}, 16'h0008);
        check("R11 alt", {8'h0, pad_alt}, 16'h0010);
        rd(3'd3, v); check("R6 analog reads one", v, 16'h0001);
        pin_in = 8'hFE;
        rd(3'd3, v); check("R7 input follows", v, 16'h00FF);
        pin_in = 8'hA0;
        rd(3'd3, v); check("R7 unlisted follow", v, 16'h00A1);
        wr(3'd0, 16'h0008);
        alt_out = 8'h00;
        #1;
        check("R10 release", {8'h0, pad_oe}, 16'h0012);
        check("R11 follows alt", {8'h0, pad_out}, 16'h0000);
        check("R8 pull down", {8'h0, pad_pull_up}, 16'h0000);
        alt_out = 8'hEF;
        #1 check("R13 unused pins", {8'h0, pad_out}, 16'h0000);
        wr(3'd6, 16'h4444);
        wr(3'd5, 16'h4444);
        #1 check("R7 float pads", {pad_oe, pad_pull_en | pad_od | pad_ana | pad_alt}, 16'h0000);
    endtask

    task automatic t_wake();
        pin_in = 8'h00;
        wr(3'd4, 16'h0005);
        @(negedge clk);
        #1 check("R12 idle", {15'd0, wake_pending}, 16'h0000);
        pin_in = 8'h02;
        #1 check("R12 unmasked", {15'd0, wake_pending}, 16'h0000);
        @(negedge clk);
        pin_in = 8'h06;
        #1 check("R12 masked rise", {15'd0, wake_pending}, 16'h0001);
        @(negedge clk);
        #1 check("R12 clears", {15'd0, wake_pending}, 16'h0000);
        pin_in = 8'h02;
        #1 check("R12 masked fall", {15'd0, wake_pending}, 16'h0001);
        @(negedge clk);
        #1 check("R12 clears again", {15'd0, wake_pending}, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        pin_in = '0; alt_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data();
        t_modes();
        t_wake();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule